// File: doc/BRIEF.md
# Three-Cycle Data Break Engine

This block moves one word at a time between a peripheral and a 12-bit word memory. It keeps no transfer count or pointer of its own. Both control words sit in main memory. The word-count cell is at a fixed address, set by a parameter. The current-address cell is the next location, modulo 4096. Software sets up a block of n words by storing -n in the count cell. It stores one less than the first target location in the address cell.

Each accepted request runs three memory cycles, and every memory access takes an extra cycle:
- **Count cycle:** read the count cell, add one and write it back.
- **Pointer cycle:** read the address cell, add one and write it back.
- **Data cycle:** use the new pointer as the data address. A device-to-memory transfer writes the device word there. A memory-to-device transfer reads that location and hands the word to the device.

Every write takes two states: one with write enable high, then one with it low and the address held. When the incremented count reaches zero, the engine sends a one-cycle block-end pulse so that the surrounding logic can raise an interrupt.

The memory port is synchronous. The read data for an address presented in one cycle arrives in the next cycle. A request is taken only while the engine is idle. A request is then busy for eight cycles. The read-data valid pulse and the block-end pulse appear in the first idle cycle after busy falls.

Top module: `dbk_engine`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, mem_we, dev_rvalid and blk_end are all 0.
- R2: When brk_req is high in an idle cycle, busy is high from the next cycle for exactly eight cycles. In the first of these, mem_addr is WC_ADDR with mem_we low.
- R3: In busy cycle 2, the engine writes the count cell: mem_addr is WC_ADDR, mem_we is 1 and mem_wdata is the value read plus 1, modulo 4096. In busy cycle 3, mem_we is 0 with the same address. mem_we is never high for two cycles in a row.
- R4: In busy cycles 4 to 6, mem_addr is WC_ADDR+1 modulo 4096. In cycle 5 the engine writes that cell with the value read plus 1, modulo 4096.
- R5: In busy cycles 7 and 8, mem_addr is the pointer value written in cycle 5. When xfer_to_mem=1, cycle 7 writes the latched device word there.
- R6: When xfer_to_mem=0, the engine reads the target in cycle 7. In the cycle after busy falls, dev_rvalid is 1 for one cycle and dev_rdata holds the word read.
- R7: blk_end is 1 for exactly the cycle after busy falls when the written-back count was 0. Otherwise it is 0.
- R8: brk_req is ignored while busy. A request present in the first idle cycle is accepted at once.
- R9: xfer_to_mem and dev_wdata are sampled only on the acceptance edge. Changes while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_req | input | 1 | Request to move one word |
| xfer_to_mem | input | 1 | 1: device word to memory; 0: memory word to device |
| dev_wdata | input | W | Word from the device |
| dev_rdata | output | W | Word read for the device |
| dev_rvalid | output | 1 | One-cycle pulse: dev_rdata is valid |
| busy | output | 1 | A transfer is in progress |
| blk_end | output | 1 | One-cycle pulse: the count reached zero |
| mem_addr | output | W | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | W | Memory read data, one cycle after the address |

## Verification
A wrong sequencer state shows at the memory port in the same cycle. It appears as a wrong address, an extra or missing write enable, or busy falling early or late. The per-cycle comparison against the model catches it within one clock. A wrong latched pointer, count-zero flag or device word only shows later. It appears at the data cycle, or in the pulses after busy falls, at most eight cycles after acceptance. Memory contents are then checked after each block.

// File: rtl/dbk_pkg.sv
// Shared types of the data break engine.
// Assumes: one state per memory cycle phase; encodings are not visible at ports.
package dbk_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_WC_RD,
        S_WC_WR,
        S_WC_END,
        S_CA_RD,
        S_CA_WR,
        S_CA_END,
        S_XFER,
        S_XFER_END,
        S_RD_CAP
    } brk_state_e;
endpackage

// File: rtl/dbk_fsm.sv
// Sequencer of the data break engine: walks count, pointer and data cycles.
// Assumes: requests are sampled only in S_IDLE; the direction is already latched
// by the datapath when S_XFER is left.
module dbk_fsm
    import dbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brk_req,
    input  logic       dir_q,
    output brk_state_e state,
    output logic       accept,
    output logic       busy
);
    brk_state_e nxt;

    // Acceptance and busy decode.
    always_comb begin
        accept = (state == S_IDLE) && brk_req;
        busy   = (state != S_IDLE);
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:     nxt = brk_req ? S_WC_RD : S_IDLE;
            S_WC_RD:    nxt = S_WC_WR;
            S_WC_WR:    nxt = S_WC_END;
            S_WC_END:   nxt = S_CA_RD;
            S_CA_RD:    nxt = S_CA_WR;
            S_CA_WR:    nxt = S_CA_END;
            S_CA_END:   nxt = S_XFER;
            S_XFER:     nxt = dir_q ? S_XFER_END : S_RD_CAP;
            S_XFER_END: nxt = S_IDLE;
            S_RD_CAP:   nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // R2: an idle request starts the count read.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && brk_req) |=> (state == S_WC_RD));

    // R8: no return to idle before the last data state.
    a_r8_no_early_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_XFER_END && state != S_RD_CAP) |=> busy);
endmodule

// File: rtl/dbk_path.sv
// Datapath of the data break engine: address/data muxing, increments and latches.
// Assumes: mem_rdata returns the word addressed in the previous cycle.
module dbk_path
    import dbk_pkg::*;
#(
    parameter int unsigned     W       = 12,
    parameter logic [W-1:0]    WC_ADDR = 12'o0010
) (
    input  logic         clk,
    input  logic         rst_n,
    input  brk_state_e   state,
    input  logic         accept,
    input  logic         xfer_to_mem,
    input  logic [W-1:0] dev_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         dir_q,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    output logic [W-1:0] dev_rdata,
    output logic         dev_rvalid,
    output logic         blk_end
);
    localparam logic [W-1:0] CA_ADDR = WC_ADDR + W'(1);

    logic [W-1:0] wd_q;
    logic [W-1:0] ptr_q;
    logic [W-1:0] inc;
    logic         last_q;

    // Increment of the word just read, modulo 2**W.
    always_comb inc = mem_rdata + W'(1);

    // Memory port drive per phase.
    always_comb begin
        mem_addr  = WC_ADDR;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state)
            S_WC_WR: begin
                mem_wdata = inc;
                mem_we    = 1'b1;
            end
            S_CA_RD, S_CA_END: mem_addr = CA_ADDR;
            S_CA_WR: begin
                mem_addr  = CA_ADDR;
                mem_wdata = inc;
                mem_we    = 1'b1;
            end
            S_XFER: begin
                mem_addr  = ptr_q;
                mem_wdata = wd_q;
                mem_we    = dir_q;
            end
            S_XFER_END, S_RD_CAP: mem_addr = ptr_q;
            default: ;
        endcase
    end

    // Latches of request fields, pointer, zero flag and read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            wd_q      <= '0;
            ptr_q     <= '0;
            last_q    <= 1'b0;
            dev_rdata <= '0;
        end else begin
            if (accept) begin
                dir_q <= xfer_to_mem;
                wd_q  <= dev_wdata;
            end
            if (state == S_WC_WR) last_q <= (inc == '0);
            if (state == S_CA_WR) ptr_q <= inc;
            if (state == S_RD_CAP) dev_rdata <= mem_rdata;
        end
    end

    // Completion pulses, one cycle after the final state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_rvalid <= 1'b0;
            blk_end    <= 1'b0;
        end else begin
            dev_rvalid <= (state == S_RD_CAP);
            blk_end    <= (state == S_RD_CAP || state == S_XFER_END) && last_q;
        end
    end

    // R3: each write lasts a single cycle.
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: the pointer cell was written just before the pointer hold state.
    a_r4_ptr_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CA_END) |-> ($past(mem_we) && $past(mem_addr) == CA_ADDR));

    // R5: the data address equals the pointer written back two cycles earlier.
    a_r5_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER) |-> (mem_addr == $past(mem_wdata, 2)));

    // R6: read-valid is a single-cycle pulse.
    a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rvalid |=> !dev_rvalid);

    // R7: block end follows a final data state.
    a_r7_end_timing: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> ($past(state) == S_XFER_END || $past(state) == S_RD_CAP));
endmodule

// File: rtl/dbk_engine.sv
// Top of the three-cycle data break engine.
// Assumes: synchronous single-port memory with one-cycle read latency;
// count cell at WC_ADDR and pointer cell at WC_ADDR+1 modulo 2**W.
module dbk_engine
    import dbk_pkg::*;
#(
    parameter int unsigned  W       = 12,
    parameter logic [W-1:0] WC_ADDR = 12'o0010
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         brk_req,
    input  logic         xfer_to_mem,
    input  logic [W-1:0] dev_wdata,
    output logic [W-1:0] dev_rdata,
    output logic         dev_rvalid,
    output logic         busy,
    output logic         blk_end,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    input  logic [W-1:0] mem_rdata
);
    brk_state_e state;
    logic       accept;
    logic       dir_q;

    dbk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_req (brk_req),
        .dir_q   (dir_q),
        .state   (state),
        .accept  (accept),
        .busy    (busy)
    );

    dbk_path #(.W(W), .WC_ADDR(WC_ADDR)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .xfer_to_mem (xfer_to_mem),
        .dev_wdata   (dev_wdata),
        .mem_rdata   (mem_rdata),
        .dir_q       (dir_q),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .dev_rdata   (dev_rdata),
        .dev_rvalid  (dev_rvalid),
        .blk_end     (blk_end)
    );
endmodule

// File: tb/sim_dbk_engine.sv
`timescale 1ns/1ps
module sim_dbk_engine;
    localparam int W = 12;
    localparam logic [11:0] WCA = 12'hFFF;
    localparam logic [11:0] CAA = 12'h000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk_req = 1'b0;
    logic xfer_to_mem = 1'b0;
    logic [11:0] dev_wdata = '0;
    logic [11:0] dev_rdata;
    logic dev_rvalid, busy, blk_end, mem_we;
    logic [11:0] mem_addr, mem_wdata;
    logic [11:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int n_end = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dbk_engine #(.W(W), .WC_ADDR(WCA)) u0 (
        .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .xfer_to_mem(xfer_to_mem),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_rvalid(dev_rvalid),
        .busy(busy), .blk_end(blk_end), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic        busy;
        logic        we;
        logic [11:0] addr;
        logic [11:0] wdata;
        logic        rv;
        logic        be;
        logic [11:0] rd;
    } exp_t;

    exp_t q[$];
    logic [11:0] mem [int];

    function automatic logic [11:0] rdm(int a);
        return mem.exists(a) ? mem[a] : 12'h000;
    endfunction

    task automatic chk(string tag, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic exp_t ent(logic b, logic we, logic [11:0] a, logic [11:0] wd);
        exp_t e;
        e.busy = b; e.we = we; e.addr = a; e.wdata = wd;
        e.rv = 1'b0; e.be = 1'b0; e.rd = '0;
        return e;
    endfunction

    // Memory model and behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        int sz;
        sz = q.size();
        if (!rst_n) q.delete();
        else begin
            if (sz > 0) void'(q.pop_front());
            if (brk_req && sz <= 1) begin
                logic [11:0] n1, p, rd;
                exp_t fin;
                n1 = rdm(int'(WCA)) + 12'd1;
                p  = rdm(int'(CAA)) + 12'd1;
                rd = (p == WCA) ? n1 : (p == CAA) ? p : rdm(int'(p));
                q.push_back(ent(1, 0, WCA, 0));
                q.push_back(ent(1, 1, WCA, n1));
                q.push_back(ent(1, 0, WCA, 0));
                q.push_back(ent(1, 0, CAA, 0));
                q.push_back(ent(1, 1, CAA, p));
                q.push_back(ent(1, 0, CAA, 0));
                q.push_back(ent(1, xfer_to_mem, p, dev_wdata));
                q.push_back(ent(1, 0, p, 0));
                fin = ent(0, 0, 0, 0);
                fin.rv = !xfer_to_mem;
                fin.rd = rd;
                fin.be = (n1 == 12'd0);
                q.push_back(fin);
            end
        end
        mem_rdata <= rdm(int'(mem_addr));
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        exp_t e;
        if (blk_end) n_end++;
        e = (q.size() > 0) ? q[0] : ent(0, 0, 0, 0);
        if (!rst_n) begin
            chk("R1 busy in reset", busy === 1'b0, busy, 0);
            chk("R1 we in reset", mem_we === 1'b0, mem_we, 0);
            chk("R1 pulses in reset", dev_rvalid === 1'b0 && blk_end === 1'b0,
                {dev_rvalid, blk_end}, 0);
        end else begin
            chk("R8 busy", busy === e.busy, busy, e.busy);
            chk("R3 mem_we", mem_we === e.we, mem_we, e.we);
            if (e.busy) chk("R4 mem_addr", mem_addr === e.addr, mem_addr, e.addr);
            if (e.we) chk("R5 mem_wdata", mem_wdata === e.wdata, mem_wdata, e.wdata);
            chk("R6 dev_rvalid", dev_rvalid === e.rv, dev_rvalid, e.rv);
            if (e.rv) chk("R6 dev_rdata", dev_rdata === e.rd, dev_rdata, e.rd);
            chk("R7 blk_end", blk_end === e.be, blk_end, e.be);
        end
    end

    task automatic xfer(logic to_mem, logic [11:0] d);
        @(negedge clk);
        brk_req = 1'b1; xfer_to_mem = to_mem; dev_wdata = d;
        @(negedge clk);
        brk_req = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", busy === 1'b0 && mem_we === 1'b0, busy, 0);

        // R3 R4 R5 R7: three-word block into memory, cells wrap around address 0.
        mem[int'(WCA)] = 12'hFFD;
        mem[int'(CAA)] = 12'h0FF;
        xfer(1, 12'hA01);
        chk("R7 no early end", n_end == 0, n_end, 0);
        xfer(1, 12'hA02);
        xfer(1, 12'hA03);
        chk("R5 word 0", rdm(12'h100) == 12'hA01, rdm(12'h100), 12'hA01);
        chk("R5 word 2", rdm(12'h102) == 12'hA03, rdm(12'h102), 12'hA03);
        chk("R3 count reaches zero", rdm(int'(WCA)) == 12'h000, rdm(int'(WCA)), 0);
        chk("R4 pointer advanced", rdm(int'(CAA)) == 12'h102, rdm(int'(CAA)), 12'h102);
        chk("R7 one block end", n_end == 1, n_end, 1);

        // R6: two-word block out of memory.
        mem[int'(WCA)] = 12'hFFE;
        mem[int'(CAA)] = 12'h0FF;
        xfer(0, 12'h000);
        xfer(0, 12'h000);
        chk("R7 read block end", n_end == 2, n_end, 2);
        chk("R6 pointer after reads", rdm(int'(CAA)) == 12'h101, rdm(int'(CAA)), 12'h101);

        // R8: request held high through busy is taken once, then again when idle.
        mem[int'(WCA)] = 12'h800;
        mem[int'(CAA)] = 12'h1FF;
        @(negedge clk);
        brk_req = 1'b1; xfer_to_mem = 1'b1; dev_wdata = 12'h555;
        repeat (9) @(negedge clk);
        chk("R8 ignored while busy", rdm(int'(CAA)) == 12'h200, rdm(int'(CAA)), 12'h200);
        @(negedge clk);
        brk_req = 1'b0;
        repeat (9) @(negedge clk);
        chk("R8 accepted when idle", rdm(int'(CAA)) == 12'h201, rdm(int'(CAA)), 12'h201);

        // R9: inputs changed while busy do not alter the transfer.
        mem[int'(CAA)] = 12'h2FF;
        @(negedge clk);
        brk_req = 1'b1; xfer_to_mem = 1'b1; dev_wdata = 12'h3C3;
        @(negedge clk);
        brk_req = 1'b0; xfer_to_mem = 1'b0; dev_wdata = 12'hFFF;
        repeat (9) @(negedge clk);
        chk("R9 latched word written", rdm(12'h300) == 12'h3C3, rdm(12'h300), 12'h3C3);

        // R2: a lone request gives exactly eight busy cycles.
        begin
            int cnt = 0;
            @(negedge clk);
            brk_req = 1'b1;
            @(negedge clk);
            brk_req = 1'b0;
            while (busy === 1'b1 && cnt < 20) begin
                cnt++;
                @(negedge clk);
            end
            chk("R2 busy length", cnt == 8, cnt, 8);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule